// File: doc/BRIEF.md
# Receive Mailbox Lock Controller

This block protects a small array of receive mailboxes so that the CPU can read a whole mailbox as one consistent unit. It watches the CPU strobes for three things: reads of a mailbox control/status word, reads of the free-running timer, and mailbox deactivation writes. It also watches the receive path, which asks to move a matched frame into a target mailbox. The CPU can configure each mailbox code through a plain write port, and it can read back codes and data words. Mailbox storage is modelled here as simple registers.

Reading the control/status word of an occupied receive mailbox locks that mailbox. The lock is dropped when the CPU reads the timer or reads the status of any other mailbox. While a mailbox is locked, a frame aimed at it waits in one holding buffer. A later frame overwrites the waiting frame and no loss is flagged. Once the lock is gone, a move-in engine copies the frame one word per cycle and keeps the mailbox BUSY while it does so. At the end it marks the mailbox FULL, or OVERRUN if the mailbox was already full. Deactivation takes priority over everything else. It clears the lock, cancels any pending frame and bars the mailbox until the next matching round.

Top module: `rx_mbox_lock_ctrl`

## Requirements
- R1: A control/status read (cs_rd_vld) of a receive mailbox whose code is FULL (4'b0010) or OVERRUN (4'b0110) and whose bit 0 (BUSY) is clear sets lock_vld=1 and lock_idx to that mailbox at the next clock edge.
- R2: An existing lock is released at the next edge by a timer read (timer_rd), or by a control/status read of a different mailbox that does not itself qualify for locking. A read of a different mailbox that does qualify moves the lock to that mailbox.
- R3: A control/status read never locks in the following cases: the code is INACTIVE (4'b0000), the code is a transmit code (bit 3 set, e.g. 4'b1100), BUSY (bit 0) is set, or the code is EMPTY (4'b0100) while strict_empty=1.
- R4: When strict_empty=0, a control/status read of an EMPTY mailbox also takes the lock.
- R5: A frame aimed at the locked mailbox stays in the holding buffer (hold_pend=1, mb_busy bit low). The move-in starts in the cycle of the unlocking read, so mb_busy rises at that same edge. A move-in never runs into a locked mailbox.
- R6: A new move-in request while a frame is pending overwrites the held frame. Only the last frame reaches the mailbox, and its code shows no loss: an EMPTY mailbox ends FULL, not OVERRUN.
- R7: A move-in copies one word per cycle over WORDS cycles. mb_busy for the target mailbox and bit 0 of its code are 1 from the edge after the request is held until the last word is written. At most one mailbox is busy at a time.
- R8: When the move-in completes, the code becomes FULL (4'b0010). If the code was FULL or OVERRUN before the move, it becomes OVERRUN (4'b0110) instead. The data words then equal the frame.
- R9: Deactivation (deact_vld) sets the code to INACTIVE, releases a lock held on that mailbox, cancels a pending frame aimed at it and sets its mb_inval bit. Requests to a mailbox with mb_inval set are dropped until round_start clears the bit.
- R10: cs_rd_code and dat_rd_data return the current mailbox code and data word in the same cycle as their index inputs.
- R11: If a control/status read and a deactivation of the same mailbox fall in one cycle, the mailbox ends unlocked. If a qualifying read and a move-in request for the same mailbox fall in one cycle, the lock wins and the frame waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strict_empty | input | 1 | 1: EMPTY mailboxes are not lockable; 0: legacy locking of EMPTY |
| cs_rd_vld | input | 1 | CPU reads a mailbox control/status word |
| cs_rd_idx | input | 3 | Mailbox index for the status read and cs_rd_code |
| cs_rd_code | output | 4 | Current code of mailbox cs_rd_idx |
| timer_rd | input | 1 | CPU reads the free-running timer (global unlock) |
| deact_vld | input | 1 | CPU deactivates a mailbox |
| deact_idx | input | 3 | Mailbox being deactivated |
| round_start | input | 1 | New matching round; clears all mb_inval bits |
| cfg_vld | input | 1 | CPU writes a mailbox code |
| cfg_idx | input | 3 | Mailbox to configure |
| cfg_code | input | 4 | Code to write (bit 0 forced low for receive codes) |
| dat_rd_idx | input | 3 | Mailbox for data read-back |
| dat_rd_word | input | 2 | Word for data read-back |
| dat_rd_data | output | 32 | Selected data word |
| mi_req_vld | input | 1 | Receive path requests a move-in |
| mi_req_idx | input | 3 | Target mailbox of the move-in |
| mi_req_data | input | 128 | Frame, word w in bits [32w+31:32w] |
| lock_vld | output | 1 | A mailbox is locked |
| lock_idx | output | 3 | Locked mailbox |
| hold_pend | output | 1 | The holding buffer has a frame waiting |
| mb_busy | output | 8 | Per-mailbox move-in in progress |
| mb_inval | output | 8 | Per-mailbox barred for the current round |

## Verification
Lock changes and holding-buffer loads appear one edge after the strobe. A move-in raises mb_busy one edge after the request is held, or at the same edge as the unlocking read. The final code and data appear WORDS edges after busy rises, and code and data read-back are combinational. The bench drives every strobe just after a rising edge and samples 1 ns after each following edge. Each scenario task counts the exact number of edges before it compares, so every wait-in-holding, busy and completion check lands on the cycle in which that result is due.

// File: rtl/rx_lock_pkg.sv
package rx_lock_pkg;

  localparam logic [3:0] CODE_INACTIVE = 4'b0000;
  localparam logic [3:0] CODE_EMPTY    = 4'b0100;
  localparam logic [3:0] CODE_FULL     = 4'b0010;
  localparam logic [3:0] CODE_OVERRUN  = 4'b0110;
  localparam int         BUSY_BIT      = 0;
  localparam int         TX_BIT        = 3;
  localparam logic [3:0] BUSY_MASK     = 4'b0001;

  // Receive mailbox, occupied, not under move-in.
  function automatic logic code_lockable(input logic [3:0] c, input logic strict);
    return !c[TX_BIT] && !c[BUSY_BIT] && (c != CODE_INACTIVE) &&
           !(strict && (c == CODE_EMPTY));
  endfunction

  // Code after a completed move-in; the busy bit is dropped.
  function automatic logic [3:0] code_after_fill(input logic [3:0] c);
    logic [3:0] base;
    base = c & ~BUSY_MASK;
    return ((base == CODE_FULL) || (base == CODE_OVERRUN)) ? CODE_OVERRUN : CODE_FULL;
  endfunction

endpackage

// File: rtl/rx_lock_tracker.sv
module rx_lock_tracker
  import rx_lock_pkg::*;
#(
  parameter  int NUM_MB = 8,
  localparam int IDX_W  = $clog2(NUM_MB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strict_empty,
  input  logic             cs_rd_vld,
  input  logic [IDX_W-1:0] cs_rd_idx,
  input  logic [3:0]       cs_rd_code,
  input  logic             timer_rd,
  input  logic             deact_vld,
  input  logic [IDX_W-1:0] deact_idx,
  output logic             lock_vld,
  output logic [IDX_W-1:0] lock_idx,
  output logic             lock_nxt_vld,
  output logic [IDX_W-1:0] lock_nxt_idx
);

  logic             vld_q;
  logic [IDX_W-1:0] idx_q;
  logic             vld_d;
  logic [IDX_W-1:0] idx_d;
  logic             rd_killed;
  logic             upd_en;

  assign rd_killed = deact_vld && (deact_idx == cs_rd_idx);

  always_comb begin
    vld_d = vld_q;
    idx_d = idx_q;
    if (cs_rd_vld) begin
      if (code_lockable(cs_rd_code, strict_empty) && !rd_killed) begin
        vld_d = 1'b1;
        idx_d = cs_rd_idx;
      end else begin
        vld_d = 1'b0;
      end
    end else if (timer_rd) begin
      vld_d = 1'b0;
    end
    // deactivation has the last word
    if (deact_vld && vld_d && (idx_d == deact_idx)) begin
      vld_d = 1'b0;
    end
  end

  assign upd_en = cs_rd_vld || timer_rd || deact_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else if (upd_en) begin
      vld_q <= vld_d;
      idx_q <= idx_d;
    end
  end

  assign lock_vld     = vld_q;
  assign lock_idx     = idx_q;
  assign lock_nxt_vld = vld_d;
  assign lock_nxt_idx = idx_d;

  // R2
  unlock_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_rd && !cs_rd_vld) |=> !lock_vld);

  // R9
  deact_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deact_vld |=> !(lock_vld && (lock_idx == $past(deact_idx))));

  // R3
  nolock_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rd_vld && ((cs_rd_code == CODE_INACTIVE) || cs_rd_code[TX_BIT] || cs_rd_code[BUSY_BIT]))
    |=> !lock_vld);

endmodule

// File: rtl/rx_hold_buffer.sv
module rx_hold_buffer
#(
  parameter  int NUM_MB = 8,
  parameter  int WORDS  = 4,
  parameter  int WORD_W = 32,
  localparam int IDX_W  = $clog2(NUM_MB),
  localparam int FRM_W  = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [FRM_W-1:0]  req_data,
  input  logic [NUM_MB-1:0] inval,
  input  logic              deact_vld,
  input  logic [IDX_W-1:0]  deact_idx,
  input  logic              take,
  output logic              pend,
  output logic [IDX_W-1:0]  idx,
  output logic [FRM_W-1:0]  data
);

  logic             pend_q;
  logic             pend_d;
  logic [IDX_W-1:0] idx_q;
  logic [FRM_W-1:0] data_q;
  logic             accept;
  logic             cancel;

  assign accept = req_vld && !inval[req_idx] && !(deact_vld && (deact_idx == req_idx));
  assign cancel = pend_q && deact_vld && (deact_idx == idx_q);

  always_comb begin
    pend_d = pend_q;
    if (accept) begin
      pend_d = 1'b1;
    end else if (take || cancel) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  // a newer frame simply overwrites the held one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      data_q <= '0;
    end else if (accept) begin
      idx_q  <= req_idx;
      data_q <= req_data;
    end
  end

  assign pend = pend_q;
  assign idx  = idx_q;
  assign data = data_q;

  // R6
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !inval[req_idx] && !(deact_vld && (deact_idx == req_idx)))
    |=> (pend && (idx == $past(req_idx))));

endmodule

// File: rtl/rx_movein_engine.sv
module rx_movein_engine
#(
  parameter  int NUM_MB = 8,
  parameter  int WORDS  = 4,
  parameter  int WORD_W = 32,
  localparam int IDX_W  = $clog2(NUM_MB),
  localparam int CNT_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int FRM_W  = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_pend,
  input  logic [IDX_W-1:0]  hold_idx,
  input  logic [FRM_W-1:0]  hold_data,
  input  logic              lock_nxt_vld,
  input  logic [IDX_W-1:0]  lock_nxt_idx,
  input  logic              deact_vld,
  input  logic [IDX_W-1:0]  deact_idx,
  output logic              start,
  output logic              act,
  output logic [IDX_W-1:0]  idx,
  output logic [CNT_W-1:0]  cnt,
  output logic [WORD_W-1:0] word,
  output logic              done
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q;
  logic [FRM_W-1:0] stage_q;
  logic             blocked;
  logic             abort;
  logic [WORD_W-1:0] stg_words [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign stg_words[w] = stage_q[w*WORD_W +: WORD_W];
  end

  // lock is resolved first: the next-state lock decides the start
  assign blocked = lock_nxt_vld && (lock_nxt_idx == hold_idx);
  assign start   = hold_pend && !act_q && !blocked &&
                   !(deact_vld && (deact_idx == hold_idx));
  assign abort   = act_q && deact_vld && (deact_idx == idx_q);

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      if (abort || (cnt_q == LAST)) begin
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      stage_q <= '0;
    end else if (start) begin
      idx_q   <= hold_idx;
      stage_q <= hold_data;
    end
  end

  assign act  = act_q;
  assign idx  = idx_q;
  assign cnt  = cnt_q;
  assign word = stg_words[cnt_q];
  assign done = act_q && (cnt_q == LAST) && !abort;

  // R7
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !abort && (cnt != LAST)) |=> (act && (cnt == $past(cnt) + CNT_W'(1))));

endmodule

// File: rtl/rx_mbox_store.sv
module rx_mbox_store
  import rx_lock_pkg::*;
#(
  parameter  int NUM_MB = 8,
  parameter  int WORDS  = 4,
  parameter  int WORD_W = 32,
  localparam int IDX_W  = $clog2(NUM_MB),
  localparam int CNT_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deact_vld,
  input  logic [IDX_W-1:0]  deact_idx,
  input  logic              round_start,
  input  logic              cfg_vld,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [3:0]        cfg_code,
  input  logic              mv_start,
  input  logic [IDX_W-1:0]  mv_start_idx,
  input  logic              mv_act,
  input  logic [IDX_W-1:0]  mv_idx,
  input  logic [CNT_W-1:0]  mv_cnt,
  input  logic [WORD_W-1:0] mv_word,
  input  logic              mv_done,
  input  logic [IDX_W-1:0]  cs_rd_idx,
  output logic [3:0]        cs_rd_code,
  input  logic [IDX_W-1:0]  dat_rd_idx,
  input  logic [CNT_W-1:0]  dat_rd_word,
  output logic [WORD_W-1:0] dat_rd_data,
  output logic [NUM_MB-1:0] busy,
  output logic [NUM_MB-1:0] inval
);

  logic [3:0]        code_arr [NUM_MB];
  logic [WORD_W-1:0] data_arr [NUM_MB][WORDS];

  for (genvar m = 0; m < NUM_MB; m++) begin : g_mb
    localparam logic [IDX_W-1:0] MB = IDX_W'(m);

    logic [3:0] code_q, code_d;
    logic       code_en;
    logic       inv_q, inv_d, inv_en;
    logic       deact_hit, start_hit, done_hit, cfg_hit, mv_here;

    assign mv_here   = mv_act && (mv_idx == MB);
    assign deact_hit = deact_vld && (deact_idx == MB);
    assign start_hit = mv_start && (mv_start_idx == MB);
    assign done_hit  = mv_done && (mv_idx == MB);
    assign cfg_hit   = cfg_vld && (cfg_idx == MB) && !mv_here;

    always_comb begin
      code_d = code_q;
      if (deact_hit) begin
        code_d = CODE_INACTIVE;
      end else if (done_hit) begin
        code_d = code_after_fill(code_q);
      end else if (start_hit) begin
        code_d = code_q | BUSY_MASK;
      end else if (cfg_hit) begin
        // software cannot fake a move-in in progress
        code_d = cfg_code[TX_BIT] ? cfg_code : (cfg_code & ~BUSY_MASK);
      end
    end

    assign code_en = deact_hit || done_hit || start_hit || cfg_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q <= CODE_INACTIVE;
      end else if (code_en) begin
        code_q <= code_d;
      end
    end

    always_comb begin
      inv_d = inv_q;
      if (deact_hit) begin
        inv_d = 1'b1;
      end else if (round_start) begin
        inv_d = 1'b0;
      end
    end

    assign inv_en = deact_hit || round_start;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inv_q <= 1'b0;
      end else if (inv_en) begin
        inv_q <= inv_d;
      end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_wd
      logic [WORD_W-1:0] word_q;
      logic              word_en;

      assign word_en = mv_here && (mv_cnt == CNT_W'(w));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= '0;
        end else if (word_en) begin
          word_q <= mv_word;
        end
      end

      assign data_arr[m][w] = word_q;
    end

    assign code_arr[m] = code_q;
    assign busy[m]     = code_q[BUSY_BIT] && !code_q[TX_BIT];
    assign inval[m]    = inv_q;
  end

  assign cs_rd_code  = code_arr[cs_rd_idx];
  assign dat_rd_data = data_arr[dat_rd_idx][dat_rd_word];

  // R7
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy) <= 1);

  // R9
  deact_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deact_vld |=> inval[$past(deact_idx)]);

endmodule

// File: rtl/rx_mbox_lock_ctrl.sv
module rx_mbox_lock_ctrl
  import rx_lock_pkg::*;
#(
  parameter  int NUM_MB = 8,
  parameter  int WORDS  = 4,
  parameter  int WORD_W = 32,
  localparam int IDX_W  = $clog2(NUM_MB),
  localparam int CNT_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int FRM_W  = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strict_empty,
  input  logic              cs_rd_vld,
  input  logic [IDX_W-1:0]  cs_rd_idx,
  output logic [3:0]        cs_rd_code,
  input  logic              timer_rd,
  input  logic              deact_vld,
  input  logic [IDX_W-1:0]  deact_idx,
  input  logic              round_start,
  input  logic              cfg_vld,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [3:0]        cfg_code,
  input  logic [IDX_W-1:0]  dat_rd_idx,
  input  logic [CNT_W-1:0]  dat_rd_word,
  output logic [WORD_W-1:0] dat_rd_data,
  input  logic              mi_req_vld,
  input  logic [IDX_W-1:0]  mi_req_idx,
  input  logic [FRM_W-1:0]  mi_req_data,
  output logic              lock_vld,
  output logic [IDX_W-1:0]  lock_idx,
  output logic              hold_pend,
  output logic [NUM_MB-1:0] mb_busy,
  output logic [NUM_MB-1:0] mb_inval
);

  logic              lock_nxt_vld;
  logic [IDX_W-1:0]  lock_nxt_idx;
  logic [IDX_W-1:0]  hold_idx;
  logic [FRM_W-1:0]  hold_data;
  logic              mv_start;
  logic              mv_act;
  logic [IDX_W-1:0]  mv_idx;
  logic [CNT_W-1:0]  mv_cnt;
  logic [WORD_W-1:0] mv_word;
  logic              mv_done;

  rx_lock_tracker #(.NUM_MB(NUM_MB)) u_lock (
    .clk          (clk),
    .rst_n        (rst_n),
    .strict_empty (strict_empty),
    .cs_rd_vld    (cs_rd_vld),
    .cs_rd_idx    (cs_rd_idx),
    .cs_rd_code   (cs_rd_code),
    .timer_rd     (timer_rd),
    .deact_vld    (deact_vld),
    .deact_idx    (deact_idx),
    .lock_vld     (lock_vld),
    .lock_idx     (lock_idx),
    .lock_nxt_vld (lock_nxt_vld),
    .lock_nxt_idx (lock_nxt_idx)
  );

  rx_hold_buffer #(.NUM_MB(NUM_MB), .WORDS(WORDS), .WORD_W(WORD_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (mi_req_vld),
    .req_idx   (mi_req_idx),
    .req_data  (mi_req_data),
    .inval     (mb_inval),
    .deact_vld (deact_vld),
    .deact_idx (deact_idx),
    .take      (mv_start),
    .pend      (hold_pend),
    .idx       (hold_idx),
    .data      (hold_data)
  );

  rx_movein_engine #(.NUM_MB(NUM_MB), .WORDS(WORDS), .WORD_W(WORD_W)) u_move (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_pend    (hold_pend),
    .hold_idx     (hold_idx),
    .hold_data    (hold_data),
    .lock_nxt_vld (lock_nxt_vld),
    .lock_nxt_idx (lock_nxt_idx),
    .deact_vld    (deact_vld),
    .deact_idx    (deact_idx),
    .start        (mv_start),
    .act          (mv_act),
    .idx          (mv_idx),
    .cnt          (mv_cnt),
    .word         (mv_word),
    .done         (mv_done)
  );

  rx_mbox_store #(.NUM_MB(NUM_MB), .WORDS(WORDS), .WORD_W(WORD_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .deact_vld    (deact_vld),
    .deact_idx    (deact_idx),
    .round_start  (round_start),
    .cfg_vld      (cfg_vld),
    .cfg_idx      (cfg_idx),
    .cfg_code     (cfg_code),
    .mv_start     (mv_start),
    .mv_start_idx (hold_idx),
    .mv_act       (mv_act),
    .mv_idx       (mv_idx),
    .mv_cnt       (mv_cnt),
    .mv_word      (mv_word),
    .mv_done      (mv_done),
    .cs_rd_idx    (cs_rd_idx),
    .cs_rd_code   (cs_rd_code),
    .dat_rd_idx   (dat_rd_idx),
    .dat_rd_word  (dat_rd_word),
    .dat_rd_data  (dat_rd_data),
    .busy         (mb_busy),
    .inval        (mb_inval)
  );

  // R5
  lock_vs_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mv_act && lock_vld && (lock_idx == mv_idx)));

endmodule

// File: tb/rx_mbox_lock_ctrl_bench.sv
module rx_mbox_lock_ctrl_bench;

  localparam int NMB = 8;
  localparam int NW  = 4;
  localparam int WW  = 32;
  localparam logic [3:0] C_INACT = 4'b0000;
  localparam logic [3:0] C_EMPTY = 4'b0100;
  localparam logic [3:0] C_FULL  = 4'b0010;
  localparam logic [3:0] C_OVR   = 4'b0110;
  localparam logic [3:0] C_TX    = 4'b1100;

  logic          clk;
  logic          rst_n;
  logic          strict_empty;
  logic          cs_rd_vld;
  logic [2:0]    cs_rd_idx;
  logic [3:0]    cs_rd_code;
  logic          timer_rd;
  logic          deact_vld;
  logic [2:0]    deact_idx;
  logic          round_start;
  logic          cfg_vld;
  logic [2:0]    cfg_idx;
  logic [3:0]    cfg_code;
  logic [2:0]    dat_rd_idx;
  logic [1:0]    dat_rd_word;
  logic [WW-1:0] dat_rd_data;
  logic          mi_req_vld;
  logic [2:0]    mi_req_idx;
  logic [NW*WW-1:0] mi_req_data;
  logic          lock_vld;
  logic [2:0]    lock_idx;
  logic          hold_pend;
  logic [NMB-1:0] mb_busy;
  logic [NMB-1:0] mb_inval;

  int checks;
  int fails;

  rx_mbox_lock_ctrl u_rx_mbox_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .strict_empty(strict_empty),
    .cs_rd_vld(cs_rd_vld), .cs_rd_idx(cs_rd_idx), .cs_rd_code(cs_rd_code),
    .timer_rd(timer_rd), .deact_vld(deact_vld), .deact_idx(deact_idx),
    .round_start(round_start), .cfg_vld(cfg_vld), .cfg_idx(cfg_idx),
    .cfg_code(cfg_code), .dat_rd_idx(dat_rd_idx), .dat_rd_word(dat_rd_word),
    .dat_rd_data(dat_rd_data), .mi_req_vld(mi_req_vld), .mi_req_idx(mi_req_idx),
    .mi_req_data(mi_req_data), .lock_vld(lock_vld), .lock_idx(lock_idx),
    .hold_pend(hold_pend), .mb_busy(mb_busy), .mb_inval(mb_inval)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [WW-1:0] fw(input int s, input int w);
    return 32'(32'h5EED_0000 + s * 16 + w);
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input logic [3:0] code);
    cfg_vld = 1'b1; cfg_idx = 3'(idx); cfg_code = code;
    cyc();
    cfg_vld = 1'b0;
  endtask

  task automatic cs_read(input int idx);
    cs_rd_vld = 1'b1; cs_rd_idx = 3'(idx);
    cyc();
    cs_rd_vld = 1'b0;
  endtask

  task automatic tmr_read();
    timer_rd = 1'b1;
    cyc();
    timer_rd = 1'b0;
  endtask

  task automatic deact(input int idx);
    deact_vld = 1'b1; deact_idx = 3'(idx);
    cyc();
    deact_vld = 1'b0;
  endtask

  task automatic load_frame(input int idx, input int s);
    mi_req_idx = 3'(idx);
    for (int w = 0; w < NW; w++) mi_req_data[w*WW +: WW] = fw(s, w);
  endtask

  task automatic send(input int idx, input int s);
    load_frame(idx, s);
    mi_req_vld = 1'b1;
    cyc();
    mi_req_vld = 1'b0;
  endtask

  task automatic chk_code(input string req, input int idx, input logic [3:0] exp);
    cs_rd_idx = 3'(idx);
    #1;
    chk(req, $sformatf("code mb%0d", idx), 32'(cs_rd_code), 32'(exp));
  endtask

  task automatic chk_frame(input string req, input int idx, input int s);
    for (int w = 0; w < NW; w++) begin
      dat_rd_idx = 3'(idx); dat_rd_word = 2'(w);
      #1;
      chk(req, $sformatf("data mb%0d w%0d", idx, w), dat_rd_data, fw(s, w));
    end
  endtask

  task automatic chk_lock(input string req, input logic v, input int idx);
    chk(req, "lock_vld", 32'(lock_vld), 32'(v));
    if (v) chk(req, "lock_idx", 32'(lock_idx), 32'(idx));
  endtask

  task automatic t_reset();
    chk("R1", "reset lock_vld", 32'(lock_vld), 0);
    chk("R5", "reset hold_pend", 32'(hold_pend), 0);
    chk("R7", "reset mb_busy", 32'(mb_busy), 0);
    chk("R9", "reset mb_inval", 32'(mb_inval), 0);
    chk_code("R10", 0, C_INACT);
  endtask

  task automatic t_movein();
    cfg(2, C_EMPTY);
    send(2, 1);
    chk("R6", "held after request", 32'(hold_pend), 1);
    chk("R7", "not busy yet", 32'(mb_busy[2]), 0);
    for (int k = 0; k < NW; k++) begin
      cyc();
      chk("R7", $sformatf("busy word %0d", k), 32'(mb_busy), 32'(8'h04));
    end
    chk_code("R10", 2, 4'b0101);
    cyc();
    chk("R7", "busy dropped", 32'(mb_busy[2]), 0);
    chk_code("R8", 2, C_FULL);
    chk_frame("R8", 2, 1);
    send(2, 2);
    wait_cyc(NW + 1);
    chk_code("R8", 2, C_OVR);
    chk_frame("R8", 2, 2);
  endtask

  task automatic t_lock_wait();
    cfg(3, C_FULL);
    cs_read(3);
    chk_lock("R1", 1'b1, 3);
    send(3, 3);
    wait_cyc(6);
    chk("R5", "frame waits", 32'(hold_pend), 1);
    chk("R5", "no busy while locked", 32'(mb_busy[3]), 0);
    chk_code("R5", 3, C_FULL);
    tmr_read();
    chk_lock("R2", 1'b0, 0);
    chk("R5", "move starts at unlock", 32'(mb_busy[3]), 1);
    wait_cyc(NW);
    chk_code("R8", 3, C_OVR);
    chk_frame("R5", 3, 3);
  endtask

  task automatic t_lock_move();
    cfg(5, C_FULL);
    cs_read(3);
    chk_lock("R1", 1'b1, 3);
    cs_read(5);
    chk_lock("R2", 1'b1, 5);
    cs_read(0);
    chk_lock("R2", 1'b0, 0);
  endtask

  task automatic t_no_lock();
    strict_empty = 1'b1;
    cfg(1, C_EMPTY);
    cs_read(1);
    chk_lock("R3", 1'b0, 0);
    cfg(4, C_TX);
    cs_read(4);
    chk_lock("R3", 1'b0, 0);
    cs_read(0);
    chk_lock("R3", 1'b0, 0);
    send(2, 4);
    cyc();
    chk("R3", "mb2 busy", 32'(mb_busy[2]), 1);
    cs_read(2);
    chk_lock("R3", 1'b0, 0);
    wait_cyc(3);
    chk_code("R8", 2, C_OVR);
    chk_frame("R3", 2, 4);
  endtask

  task automatic t_legacy();
    strict_empty = 1'b0;
    cs_read(1);
    chk_lock("R4", 1'b1, 1);
    tmr_read();
    chk_lock("R4", 1'b0, 0);
    strict_empty = 1'b1;
  endtask

  task automatic t_overwrite();
    strict_empty = 1'b0;
    cfg(6, C_EMPTY);
    cs_read(6);
    chk_lock("R4", 1'b1, 6);
    send(6, 10);
    send(6, 11);
    wait_cyc(2);
    chk("R6", "still held", 32'(hold_pend), 1);
    chk("R6", "not busy", 32'(mb_busy[6]), 0);
    tmr_read();
    wait_cyc(NW);
    chk_code("R6", 6, C_FULL);
    chk_frame("R6", 6, 11);
    strict_empty = 1'b1;
  endtask

  task automatic t_deact();
    cfg(7, C_FULL);
    cs_read(7);
    chk_lock("R9", 1'b1, 7);
    send(7, 20);
    deact(7);
    chk_lock("R9", 1'b0, 0);
    chk("R9", "pending cancelled", 32'(hold_pend), 0);
    chk("R9", "inval set", 32'(mb_inval[7]), 1);
    chk_code("R9", 7, C_INACT);
    wait_cyc(NW + 1);
    chk("R9", "no move-in", 32'(mb_busy[7]), 0);
    send(7, 21);
    chk("R9", "request dropped", 32'(hold_pend), 0);
    round_start = 1'b1;
    cyc();
    round_start = 1'b0;
    chk("R9", "inval cleared", 32'(mb_inval[7]), 0);
    cfg(7, C_EMPTY);
    send(7, 22);
    wait_cyc(NW + 1);
    chk_code("R9", 7, C_FULL);
    chk_frame("R9", 7, 22);
  endtask

  task automatic t_same_cycle();
    cs_rd_vld = 1'b1; cs_rd_idx = 3'd5;
    deact_vld = 1'b1; deact_idx = 3'd5;
    cyc();
    cs_rd_vld = 1'b0; deact_vld = 1'b0;
    chk_lock("R11", 1'b0, 0);
    chk_code("R11", 5, C_INACT);
    round_start = 1'b1;
    cyc();
    round_start = 1'b0;
    cfg(5, C_FULL);
    load_frame(5, 30);
    mi_req_vld = 1'b1;
    cs_rd_vld = 1'b1; cs_rd_idx = 3'd5;
    cyc();
    mi_req_vld = 1'b0; cs_rd_vld = 1'b0;
    chk_lock("R11", 1'b1, 5);
    wait_cyc(3);
    chk("R11", "frame held", 32'(hold_pend), 1);
    chk("R11", "no busy", 32'(mb_busy[5]), 0);
    tmr_read();
    chk("R5", "busy at unlock", 32'(mb_busy[5]), 1);
    wait_cyc(NW);
    chk_code("R8", 5, C_OVR);
    chk_frame("R11", 5, 30);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; strict_empty = 1'b1;
    cs_rd_vld = 1'b0; cs_rd_idx = '0; timer_rd = 1'b0;
    deact_vld = 1'b0; deact_idx = '0; round_start = 1'b0;
    cfg_vld = 1'b0; cfg_idx = '0; cfg_code = '0;
    dat_rd_idx = '0; dat_rd_word = '0;
    mi_req_vld = 1'b0; mi_req_idx = '0; mi_req_data = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_movein();
    t_lock_wait();
    t_lock_move();
    t_no_lock();
    t_legacy();
    t_overwrite();
    t_deact();
    t_same_cycle();
    summary();
    $finish;
  end

endmodule